// File: doc/BRIEF.md
# Serial PSRAM Bring-Up Sequencer

This block runs once after reset to take a serial pseudo-static RAM from an unknown lane state into quad-lane operation. It does not shift bits itself. It drives a command-issue interface toward a lower-level shifter and waits for each command to complete. That interface carries an opcode, a lane-mode flag, an address-phase length, a receive length and a start/done handshake. The shifter returns any received word together with its done strobe.

The sequence has five steps:
1. Force the device out of quad mode.
2. Read its 24-bit identification word.
3. Check the known-good-die byte and decode the density from the extended-ID byte.
4. Reset the device with a two-command pair.
5. Switch the device into quad mode.

An ID that fails validation is read once more before the block gives up with an error. When the bring-up is over, the block reports completion, failure, a two-bit density code and a flag that marks an early 32 Mbit part needing an extended clock scheme.

Once the device is ready, the block also accepts wrap-length requests. It only forwards the supported sizes to the device. Every other size is refused at once.

Top module: `psram_bringup_seq`

## Requirements
- R1: After reset, the first command issued is opcode 0xF5 with `cmd_quad`=1, zero address bits and zero receive bits.
- R2: The ID read uses opcode 0x9F with `cmd_quad`=0, 24 address bits and 24 receive bits. It is the second command issued.
- R3: At most one command is outstanding at a time. `cmd_start` is a single-cycle pulse, and no new pulse appears until `cmd_done` has answered the previous one.
- R4: An ID is valid when bits 15:8 equal 0x5D. If the first ID is invalid, exactly one more 0x9F read is issued.
- R5: If the second ID is also invalid, `init_done` and `init_err` both go high, stay high, and no further command is issued.
- R6: For a valid ID, let E be bits 23:16. `size_code` is 2 when E equals 0x26 or when E[7:5]=2. Otherwise it is 1 when E[7:5]=1, 0 when E[7:5]=0, and 3 (invalid) for any other E[7:5]. In every case `init_done` rises with `init_err`=0.
- R7: `legacy_clk` is 1 only when the accepted ID has E equal to exactly 0x20.
- R8: After a valid ID, the block issues 0x66, then 0x99, then 0x35, all with `cmd_quad`=0, zero address bits and zero receive bits. It then raises `init_done`.
- R9: In the ready state, a `wrap_req` with `wrap_size` 0 or 32 issues opcode 0xC0 with `cmd_quad`=1. A single `wrap_ack` pulse follows once that command is done.
- R10: In the ready state, a `wrap_req` with any other `wrap_size` value produces a single `wrap_nack` pulse and issues no command.
- R11: A `wrap_req` received before `init_done` is ignored. It issues no 0xC0 command and produces no `wrap_ack` or `wrap_nack`.
- R12: While reset is held, `cmd_start`, `init_done`, `init_err`, `legacy_clk`, `wrap_ack` and `wrap_nack` are 0, and `size_code` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | output | 1 | One-cycle pulse that launches a command on the shifter |
| cmd_opcode | output | 8 | Opcode of the current command |
| cmd_quad | output | 1 | 1 = quad lanes, 0 = single lane |
| cmd_addr_bits | output | 6 | Address-phase length in bits |
| cmd_rx_bits | output | 6 | Receive-phase length in bits |
| cmd_done | input | 1 | Shifter completion strobe |
| cmd_rx_data | input | ID_W | Received word, valid together with `cmd_done` |
| wrap_req | input | 1 | Request to set the device wrap length |
| wrap_size | input | WRAP_W | Requested wrap length in bytes |
| wrap_ack | output | 1 | Pulse: wrap command completed |
| wrap_nack | output | 1 | Pulse: wrap size refused |
| init_done | output | 1 | Bring-up finished, with or without error |
| init_err | output | 1 | Both ID reads failed validation |
| size_code | output | 2 | Density: 0=16 Mbit, 1=32 Mbit, 2=64 Mbit, 3=unknown |
| legacy_clk | output | 1 | Early 32 Mbit part needing an extended clock mode |

## Verification
The bench sweeps all 256 extended-ID values behind a valid die byte. A decoder that tested the whole byte instead of bits 7:5, or that forgot the 0x26 special case, would report the wrong density. One that matched the legacy value loosely would raise `legacy_clk` for neighbours of 0x20.

It then sweeps every invalid die byte on the first read. A design that skipped the retry would end in error. One that retried without bound would issue a third 0x9F when both reads fail.

All 256 wrap sizes are presented in the ready state. This catches a check that refuses 32 or lets 16 or 64 through. Wrap requests made during bring-up must leave the command log free of 0xC0 and must produce no ack or nack pulse.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

   localparam int OP_W  = 8;
   localparam int LEN_W = 6;

   localparam logic [OP_W-1:0] OP_QUAD_EXIT  = 8'hF5;
   localparam logic [OP_W-1:0] OP_READ_ID    = 8'h9F;
   localparam logic [OP_W-1:0] OP_RESET_ARM  = 8'h66;
   localparam logic [OP_W-1:0] OP_RESET_FIRE = 8'h99;
   localparam logic [OP_W-1:0] OP_QUAD_ENTER = 8'h35;
   localparam logic [OP_W-1:0] OP_WRAP_LEN   = 8'hC0;

   typedef enum logic [1:0] {
      SZ_16M = 2'd0,
      SZ_32M = 2'd1,
      SZ_64M = 2'd2,
      SZ_BAD = 2'd3
   } dens_t;

   typedef struct packed {
      logic [OP_W-1:0]  op;
      logic             quad;
      logic [LEN_W-1:0] abits;
      logic [LEN_W-1:0] rbits;
   } cmd_t;

   typedef enum logic [3:0] {
      ST_EXIT,
      ST_ID,
      ST_ID_CHK,
      ST_RST_ARM,
      ST_RST_FIRE,
      ST_QENTER,
      ST_READY,
      ST_WRAP,
      ST_FAIL
   } seq_state_t;

endpackage

// File: rtl/psram_id_decode.sv
module psram_id_decode
   import psram_seq_pkg::*;
#(
   parameter int         ID_W        = 24,
   parameter logic [7:0] KGD_VALUE   = 8'h5D,
   parameter logic [7:0] LEGACY_EID  = 8'h20,
   parameter logic [7:0] TRIAL64_EID = 8'h26
) (
   input  logic [ID_W-1:0] id_word,
   output logic            id_ok,
   output logic [1:0]      id_size,
   output logic            id_legacy
);

   logic [7:0] kgd_byte;
   logic [7:0] ext_byte;
   logic [2:0] dens_fld;
   logic       unused_bits;

   assign kgd_byte    = id_word[15:8];
   assign ext_byte    = id_word[23:16];
   assign dens_fld    = ext_byte[7:5];
   assign unused_bits = ^id_word;

   assign id_ok     = (kgd_byte == KGD_VALUE);
   assign id_legacy = (ext_byte == LEGACY_EID);

   always_comb begin
      if (ext_byte == TRIAL64_EID || dens_fld == 3'd2) id_size = SZ_64M;
      else if (dens_fld == 3'd1)                       id_size = SZ_32M;
      else if (dens_fld == 3'd0)                       id_size = SZ_16M;
      else                                             id_size = SZ_BAD;
   end

endmodule

// File: rtl/psram_cmd_port.sv
module psram_cmd_port
   import psram_seq_pkg::*;
#(
   parameter int ID_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  cmd_t             req_cmd,
   output logic             busy,
   output logic             fin,
   output logic [ID_W-1:0]  rx_word,
   output logic             cmd_start,
   output logic [OP_W-1:0]  cmd_opcode,
   output logic             cmd_quad,
   output logic [LEN_W-1:0] cmd_addr_bits,
   output logic [LEN_W-1:0] cmd_rx_bits,
   input  logic             cmd_done,
   input  logic [ID_W-1:0]  cmd_rx_data
);

   cmd_t held;

   assign cmd_opcode    = held.op;
   assign cmd_quad      = held.quad;
   assign cmd_addr_bits = held.abits;
   assign cmd_rx_bits   = held.rbits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= '0;
         busy      <= 1'b0;
         fin       <= 1'b0;
         cmd_start <= 1'b0;
         rx_word   <= '0;
      end else begin
         cmd_start <= 1'b0;
         fin       <= 1'b0;
         if (req && !busy) begin
            held      <= req_cmd;
            busy      <= 1'b1;
            cmd_start <= 1'b1;
         end else if (busy && !cmd_start && cmd_done) begin
            busy    <= 1'b0;
            fin     <= 1'b1;
            rx_word <= cmd_rx_data;
         end
      end
   end

   // R3: launch pulse is a single cycle
   assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> !cmd_start);
   // R3: the sequencer never asks while a command is in flight
   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> !busy);
   // R3: completion only follows a shifter done
   assert_fin_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> $past(cmd_done));

endmodule

// File: rtl/psram_seq_ctrl.sv
module psram_seq_ctrl
   import psram_seq_pkg::*;
#(
   parameter int ADDR_BITS = 24,
   parameter int ID_W      = 24,
   parameter int ID_TRIES  = 2,
   parameter int WRAP_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              fin,
   input  logic              id_ok,
   input  logic [1:0]        id_size,
   input  logic              id_legacy,
   input  logic              wrap_req,
   input  logic [WRAP_W-1:0] wrap_size,
   output logic              req,
   output cmd_t              req_cmd,
   output logic              init_done,
   output logic              init_err,
   output logic [1:0]        size_code,
   output logic              legacy_clk,
   output logic              wrap_ack,
   output logic              wrap_nack
);

   localparam logic [LEN_W-1:0] ABITS = LEN_W'(ADDR_BITS);
   localparam logic [LEN_W-1:0] RBITS = LEN_W'(ID_W);

   seq_state_t state;
   logic       issued;
   logic       cmd_state;
   logic       retry_left;
   logic       wrap_fits;

   assign wrap_fits = (wrap_size == WRAP_W'(0)) || (wrap_size == WRAP_W'(32));

   always_comb begin
      cmd_state = 1'b1;
      req_cmd   = '{op: OP_QUAD_EXIT, quad: 1'b1, abits: '0, rbits: '0};
      unique case (state)
         ST_EXIT:     req_cmd = '{op: OP_QUAD_EXIT,  quad: 1'b1, abits: '0,    rbits: '0};
         ST_ID:       req_cmd = '{op: OP_READ_ID,    quad: 1'b0, abits: ABITS, rbits: RBITS};
         ST_RST_ARM:  req_cmd = '{op: OP_RESET_ARM,  quad: 1'b0, abits: '0,    rbits: '0};
         ST_RST_FIRE: req_cmd = '{op: OP_RESET_FIRE, quad: 1'b0, abits: '0,    rbits: '0};
         ST_QENTER:   req_cmd = '{op: OP_QUAD_ENTER, quad: 1'b0, abits: '0,    rbits: '0};
         ST_WRAP:     req_cmd = '{op: OP_WRAP_LEN,   quad: 1'b1, abits: '0,    rbits: '0};
         default:     cmd_state = 1'b0;
      endcase
   end

   assign req = cmd_state && !issued && !busy;

   generate
      if (ID_TRIES > 1) begin : g_retry
         localparam int TRY_W = $clog2(ID_TRIES);
         logic [TRY_W-1:0] tries;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       tries <= '0;
            else if (state == ST_ID_CHK && !id_ok && retry_left) tries <= tries + 1'b1;
         end
         assign retry_left = (tries != TRY_W'(ID_TRIES - 1));
      end else begin : g_single
         assign retry_left = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_EXIT;
         issued     <= 1'b0;
         size_code  <= SZ_BAD;
         legacy_clk <= 1'b0;
         wrap_ack   <= 1'b0;
         wrap_nack  <= 1'b0;
      end else begin
         wrap_ack  <= 1'b0;
         wrap_nack <= 1'b0;
         if (req) issued <= 1'b1;
         if (fin) begin
            issued <= 1'b0;
            unique case (state)
               ST_EXIT:     state <= ST_ID;
               ST_ID:       state <= ST_ID_CHK;
               ST_RST_ARM:  state <= ST_RST_FIRE;
               ST_RST_FIRE: state <= ST_QENTER;
               ST_QENTER:   state <= ST_READY;
               ST_WRAP: begin
                  state    <= ST_READY;
                  wrap_ack <= 1'b1;
               end
               default:     state <= state;
            endcase
         end else if (state == ST_ID_CHK) begin
            if (id_ok) begin
               size_code  <= id_size;
               legacy_clk <= id_legacy;
               state      <= ST_RST_ARM;
            end else if (retry_left) begin
               state <= ST_ID;
            end else begin
               state <= ST_FAIL;
            end
         end else if (state == ST_READY && wrap_req) begin
            if (wrap_fits) state     <= ST_WRAP;
            else           wrap_nack <= 1'b1;
         end
      end
   end

   assign init_done = (state == ST_READY) || (state == ST_WRAP) || (state == ST_FAIL);
   assign init_err  = (state == ST_FAIL);

   // R5: a failed bring-up is final
   assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      init_err |=> init_err);
   // R5: nothing is launched after failure
   assert_fail_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      init_err |-> !req);
   // R9, R10: a wrap request ends in exactly one kind of answer
   assert_wrap_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wrap_ack && wrap_nack));
   // R10: a refusal only comes from the ready state
   assert_nack_from_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_nack |-> $past(state) == ST_READY);

endmodule

// File: rtl/psram_bringup_seq.sv
module psram_bringup_seq
   import psram_seq_pkg::*;
#(
   parameter int         ID_W        = 24,
   parameter int         ADDR_BITS   = 24,
   parameter int         ID_TRIES    = 2,
   parameter int         WRAP_W      = 8,
   parameter logic [7:0] KGD_VALUE   = 8'h5D,
   parameter logic [7:0] LEGACY_EID  = 8'h20,
   parameter logic [7:0] TRIAL64_EID = 8'h26
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cmd_start,
   output logic [OP_W-1:0]   cmd_opcode,
   output logic              cmd_quad,
   output logic [LEN_W-1:0]  cmd_addr_bits,
   output logic [LEN_W-1:0]  cmd_rx_bits,
   input  logic              cmd_done,
   input  logic [ID_W-1:0]   cmd_rx_data,
   input  logic              wrap_req,
   input  logic [WRAP_W-1:0] wrap_size,
   output logic              wrap_ack,
   output logic              wrap_nack,
   output logic              init_done,
   output logic              init_err,
   output logic [1:0]        size_code,
   output logic              legacy_clk
);

   generate
      if (ID_W < 24 || ID_W >= (1 << LEN_W))
         $error("ID_W must hold both ID bytes and fit the length field");
      if (ADDR_BITS < 0 || ADDR_BITS >= (1 << LEN_W))
         $error("ADDR_BITS must fit the length field");
      if (ID_TRIES < 1)
         $error("ID_TRIES must be at least one");
      if (WRAP_W < 6)
         $error("WRAP_W must be able to express 32");
   endgenerate

   logic            busy;
   logic            fin;
   logic            req;
   cmd_t            req_cmd;
   logic [ID_W-1:0] rx_word;
   logic            id_ok;
   logic [1:0]      id_size;
   logic            id_legacy;

   psram_cmd_port #(.ID_W(ID_W)) u_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .req           (req),
      .req_cmd       (req_cmd),
      .busy          (busy),
      .fin           (fin),
      .rx_word       (rx_word),
      .cmd_start     (cmd_start),
      .cmd_opcode    (cmd_opcode),
      .cmd_quad      (cmd_quad),
      .cmd_addr_bits (cmd_addr_bits),
      .cmd_rx_bits   (cmd_rx_bits),
      .cmd_done      (cmd_done),
      .cmd_rx_data   (cmd_rx_data)
   );

   psram_id_decode #(
      .ID_W        (ID_W),
      .KGD_VALUE   (KGD_VALUE),
      .LEGACY_EID  (LEGACY_EID),
      .TRIAL64_EID (TRIAL64_EID)
   ) u_dec (
      .id_word   (rx_word),
      .id_ok     (id_ok),
      .id_size   (id_size),
      .id_legacy (id_legacy)
   );

   psram_seq_ctrl #(
      .ADDR_BITS (ADDR_BITS),
      .ID_W      (ID_W),
      .ID_TRIES  (ID_TRIES),
      .WRAP_W    (WRAP_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (busy),
      .fin        (fin),
      .id_ok      (id_ok),
      .id_size    (id_size),
      .id_legacy  (id_legacy),
      .wrap_req   (wrap_req),
      .wrap_size  (wrap_size),
      .req        (req),
      .req_cmd    (req_cmd),
      .init_done  (init_done),
      .init_err   (init_err),
      .size_code  (size_code),
      .legacy_clk (legacy_clk),
      .wrap_ack   (wrap_ack),
      .wrap_nack  (wrap_nack)
   );

   // R2: ID reads go out on a single lane with full address and receive phases
   assert_id_read_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && cmd_opcode == OP_READ_ID) |->
         (!cmd_quad && cmd_addr_bits == LEN_W'(ADDR_BITS) && cmd_rx_bits == LEN_W'(ID_W)));
   // R7: the legacy part is always a 32 Mbit part
   assert_legacy_density_R7: assert property (@(posedge clk) disable iff (!rst_n)
      legacy_clk |-> size_code == SZ_32M);
   // R11: the wrap opcode never leaves before bring-up completes
   assert_wrap_after_init_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && cmd_opcode == OP_WRAP_LEN) |-> init_done);

endmodule

// File: tb/sim_psram_bringup_seq.sv
module sim_psram_bringup_seq;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start, cmd_quad, cmd_done;
   logic [7:0]  cmd_opcode;
   logic [5:0]  cmd_addr_bits, cmd_rx_bits;
   logic [23:0] cmd_rx_data;
   logic        wrap_req;
   logic [7:0]  wrap_size;
   logic        wrap_ack, wrap_nack, init_done, init_err, legacy_clk;
   logic [1:0]  size_code;

   always #(CLK_PERIOD/2) clk = ~clk;

   psram_bringup_seq u0 (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_opcode(cmd_opcode),
      .cmd_quad(cmd_quad), .cmd_addr_bits(cmd_addr_bits), .cmd_rx_bits(cmd_rx_bits),
      .cmd_done(cmd_done), .cmd_rx_data(cmd_rx_data), .wrap_req(wrap_req),
      .wrap_size(wrap_size), .wrap_ack(wrap_ack), .wrap_nack(wrap_nack),
      .init_done(init_done), .init_err(init_err), .size_code(size_code),
      .legacy_clk(legacy_clk)
   );

   int          total = 0;
   int          bad = 0;
   bit          finished = 0;
   logic [7:0]  log_op [0:15];
   logic        log_q  [0:15];
   int          log_ab [0:15];
   int          log_rb [0:15];
   int          n_ops, n_ack, n_nack, overlap, id_idx;
   logic [23:0] id_q [0:1];

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic flags();
      if (wrap_ack)  n_ack++;
      if (wrap_nack) n_nack++;
   endtask

   // shifter model
   initial begin
      logic [23:0] rx;
      cmd_done = 1'b0;
      cmd_rx_data = '0;
      forever begin
         @(negedge clk);
         flags();
         if (cmd_start) begin
            if (n_ops < 16) begin
               log_op[n_ops] = cmd_opcode;
               log_q[n_ops]  = cmd_quad;
               log_ab[n_ops] = int'(cmd_addr_bits);
               log_rb[n_ops] = int'(cmd_rx_bits);
            end
            n_ops++;
            rx = '0;
            if (cmd_opcode == 8'h9F) begin
               rx = id_q[(id_idx > 1) ? 1 : id_idx];
               id_idx++;
            end
            for (int i = 0; i < LAT; i++) begin
               @(negedge clk); flags();
               if (cmd_start) overlap++;
            end
            cmd_done = 1'b1;
            cmd_rx_data = rx;
            @(negedge clk); flags();
            if (cmd_start) overlap++;
            cmd_done = 1'b0;
            cmd_rx_data = '0;
         end
      end
   end

   task automatic clear_logs();
      n_ops = 0; n_ack = 0; n_nack = 0; overlap = 0; id_idx = 0;
   endtask

   task automatic run_init(input logic [23:0] a, input logic [23:0] b);
      rst_n = 1'b0;
      wrap_req = 1'b0;
      repeat (2) @(negedge clk);
      clear_logs();
      id_q[0] = a;
      id_q[1] = b;
      rst_n = 1'b1;
      for (int i = 0; i < 200 && !init_done; i++) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   task automatic chk_op(input int k, input logic [7:0] op, input logic q,
                         input int ab, input int rb, input string tag);
      chk({tag, " opcode"}, int'(log_op[k]), int'(op));
      chk({tag, " lane"},   int'(log_q[k]),  int'(q));
      chk({tag, " abits"},  log_ab[k], ab);
      chk({tag, " rbits"},  log_rb[k], rb);
   endtask

   task automatic chk_tail(input int base);
      chk_op(base,     8'h66, 1'b0, 0, 0, "R8 reset-arm");
      chk_op(base + 1, 8'h99, 1'b0, 0, 0, "R8 reset-fire");
      chk_op(base + 2, 8'h35, 1'b0, 0, 0, "R8 quad-enter");
   endtask

   initial begin
      int exp_sz;
      logic [7:0] e;
      wrap_req = 1'b0;
      wrap_size = '0;
      clear_logs();
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 cmd_start", int'(cmd_start), 0);
      chk("R12 init_done", int'(init_done), 0);
      chk("R12 init_err", int'(init_err), 0);
      chk("R12 size_code", int'(size_code), 3);
      chk("R12 legacy_clk", int'(legacy_clk), 0);
      chk("R12 wrap pulses", int'(wrap_ack | wrap_nack), 0);

      // R6, R7, R1, R2, R8: every extended-ID value behind a good die byte
      for (int x = 0; x < 256; x++) begin
         e = 8'(x);
         run_init({e, 8'h5D, 8'hA5}, 24'h0);
         exp_sz = (e == 8'h26 || e[7:5] == 3'd2) ? 2 :
                  (e[7:5] == 3'd1) ? 1 : (e[7:5] == 3'd0) ? 0 : 3;
         chk("R8 command count", n_ops, 5);
         chk_op(0, 8'hF5, 1'b1, 0, 0, "R1 first command");
         chk_op(1, 8'h9F, 1'b0, 24, 24, "R2 id read");
         chk_tail(2);
         chk("R6 init_done", int'(init_done), 1);
         chk("R6 init_err", int'(init_err), 0);
         chk("R6 size_code", int'(size_code), exp_sz);
         chk("R7 legacy_clk", int'(legacy_clk), int'(e == 8'h20));
         chk("R3 overlap", overlap, 0);
      end

      // R4: every bad die byte on the first read, second read good
      for (int k = 0; k < 256; k++) begin
         if (k == 8'h5D) continue;
         run_init({8'h40, 8'(k), 8'h00}, {8'h20, 8'h5D, 8'h11});
         chk("R4 command count", n_ops, 6);
         chk_op(1, 8'h9F, 1'b0, 24, 24, "R4 first read");
         chk_op(2, 8'h9F, 1'b0, 24, 24, "R4 retry read");
         chk_tail(3);
         chk("R4 size from retry", int'(size_code), 1);
         chk("R4 legacy from retry", int'(legacy_clk), 1);
         chk("R4 no error", int'(init_err), 0);
         chk("R3 overlap", overlap, 0);
      end

      // R5: both reads bad
      run_init({8'h40, 8'h5C, 8'h00}, {8'h40, 8'h5E, 8'h00});
      repeat (30) @(negedge clk);
      chk("R5 command count", n_ops, 3);
      chk("R5 init_done", int'(init_done), 1);
      chk("R5 init_err", int'(init_err), 1);
      chk("R5 size stays unknown", int'(size_code), 3);

      // R11: wrap requests during bring-up are ignored
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      clear_logs();
      id_q[0] = {8'h40, 8'h5D, 8'h00};
      id_q[1] = 24'h0;
      rst_n = 1'b1;
      wrap_req = 1'b1;
      wrap_size = 8'd0;
      repeat (4) @(negedge clk);
      wrap_size = 8'd5;
      repeat (4) @(negedge clk);
      wrap_req = 1'b0;
      for (int i = 0; i < 200 && !init_done; i++) @(negedge clk);
      repeat (10) @(negedge clk);
      chk("R11 command count", n_ops, 5);
      chk("R11 no ack", n_ack, 0);
      chk("R11 no nack", n_nack, 0);
      chk("R11 density", int'(size_code), 2);

      // R9, R10: every wrap size in the ready state
      for (int s = 0; s < 256; s++) begin
         clear_logs();
         wrap_req = 1'b1;
         wrap_size = 8'(s);
         @(negedge clk);
         wrap_req = 1'b0;
         repeat (15) @(negedge clk);
         if (s == 0 || s == 32) begin
            chk("R9 command count", n_ops, 1);
            chk_op(0, 8'hC0, 1'b1, 0, 0, "R9 wrap command");
            chk("R9 ack", n_ack, 1);
            chk("R9 nack", n_nack, 0);
         end else begin
            chk("R10 command count", n_ops, 0);
            chk("R10 ack", n_ack, 0);
            chk("R10 nack", n_nack, 1);
         end
      end

      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule